// File: doc/BRIEF.md
# Pipelined Half-Precision Fused Multiply-Add

This block computes `y = a * b + c` on three 16-bit floating-point operands. Each word holds, from the most significant end, a 1-bit sign, a 5-bit biased exponent (bias 15) and a 10-bit fraction with an implied leading one. The product is never rounded on its own. The full 22-bit significand product and the addend are summed exactly, apart from a sticky bit, and the result is rounded once to nearest, with ties going to even.

The work is split over four registered stages. Stage 1 captures the operands. Stage 2 forms the significand product while it derives the product exponent and shifts the operand with the smaller exponent into place. Stage 3 adds or subtracts and counts leading zeros. Stage 4 normalizes, rounds and clamps on overflow. A valid flag travels through the stages with the data, so a new operation may start on every cycle. Idle cycles pass through as bubbles.

Top module: `hfma`

## Requirements
- R1: `out_valid` is high in cycle n+4 exactly when `in_valid` was high in cycle n. The result of that operation is on `y_out` in the same cycle.
- R2: For normal operands, `y_out` equals the exact value of a*b+c rounded once to 11 significant bits, to nearest with ties to even.
- R3: If the rounded exponent reaches 31 or more, the result is infinity (exponent field 31, fraction 0) with the sign of the exact sum. This includes the case where rounding carries the value past the largest finite number.
- R4: When nonzero terms cancel exactly, the result is +0 (16'h0000). When both the product and the addend are zero, the result is a zero whose sign bit is set only if both the product sign and the addend sign are negative.
- R5: An operand with exponent field 0 is treated as zero, whatever its fraction. A rounded result whose exponent would be 0 or less is output as a zero that keeps the sign of the sum. No output ever has exponent 0 with a nonzero fraction.
- R6: An operand with exponent 31 and a nonzero fraction, infinity times zero, or an infinite product added to an infinite addend of opposite sign gives the quiet NaN 16'h7E00. Any other infinite term gives infinity with that term's sign.
- R7: While `rst_n` is low, `out_valid` and `y_out` are zero.
- R8: When rounding up makes the significand overflow to 2.0, the result is 1.0 times 2 to the next higher exponent.
- R9: Bits of the smaller-exponent term that are shifted below the rounding position still decide the rounding: exactly half an ulp ties to even, and anything more or less than half rounds away or toward the nearer value. This holds for both addition and subtraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks an operation presented on the operand inputs this cycle |
| a_in | input | 16 | Multiplicand |
| b_in | input | 16 | Multiplier |
| c_in | input | 16 | Addend |
| out_valid | output | 1 | Marks a finished result on `y_out` |
| y_out | output | 16 | Rounded result |

## Verification
Every result, including special values, flushed zeros and overflow, is due exactly four clock cycles after the cycle in which it was presented. There is no early path for special cases. The bench drives one cycle at a time on the falling edge and keeps a four-entry queue of expected valid flags and results, which it builds with wide-integer arithmetic. On each falling edge it pops the entry for the operation presented four cycles earlier. It compares `out_valid` against that entry in every cycle, including bubble cycles, and compares `y_out` whenever the entry is marked valid.

// File: rtl/hfma.sv
module hfma #(
  parameter int EW = 5,
  parameter int MW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [EW+MW:0]    a_in,
  input  logic [EW+MW:0]    b_in,
  input  logic [EW+MW:0]    c_in,
  output logic              out_valid,
  output logic [EW+MW:0]    y_out
);
  localparam int FW   = EW + MW + 1;
  localparam int SW   = MW + 1;
  localparam int PW   = 2 * SW;
  localparam int WN   = 2 * PW + 6;
  localparam int XW   = EW + 4;
  localparam int LZW  = $clog2(WN + 2);
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int EMAX = (1 << EW) - 1;
  localparam logic signed [XW-1:0] BIASX = XW'(BIAS);
  localparam logic signed [XW-1:0] EMAXX = XW'(EMAX);
  localparam logic signed [XW-1:0] WNX   = XW'(WN);
  localparam logic [FW-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};
  localparam logic [FW-1:0] PINF = {1'b0, {EW{1'b1}}, {MW{1'b0}}};

  function automatic logic signed [XW-1:0] sx(input logic [EW-1:0] e);
    return $signed({{(XW-EW){1'b0}}, e});
  endfunction

  // stage 1: operand capture
  logic          v1;
  logic [FW-1:0] a1, b1, c1;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v1 <= 1'b0; a1 <= '0; b1 <= '0; c1 <= '0;
    end else begin
      v1 <= in_valid; a1 <= a_in; b1 <= b_in; c1 <= c_in;
    end

  // stage 2: multiply, exponents, alignment, special cases
  logic          sa, sb, sc, sp;
  logic [EW-1:0] ea, eb, ec;
  logic [MW-1:0] fa, fb, fc;
  assign {sa, ea, fa} = a1;
  assign {sb, eb, fb} = b1;
  assign {sc, ec, fc} = c1;
  assign sp = sa ^ sb;

  logic az, bz, cz, ai, bi, ci, an, bn, cn, pz;
  assign az = (ea == '0);
  assign bz = (eb == '0);
  assign cz = (ec == '0);
  assign ai = (ea == EW'(EMAX)) && (fa == '0);
  assign bi = (eb == EW'(EMAX)) && (fb == '0);
  assign ci = (ec == EW'(EMAX)) && (fc == '0);
  assign an = (ea == EW'(EMAX)) && (fa != '0);
  assign bn = (eb == EW'(EMAX)) && (fb != '0);
  assign cn = (ec == EW'(EMAX)) && (fc != '0);
  assign pz = az | bz;

  logic [PW-1:0] prod;
  assign prod = {{SW{1'b0}}, 1'b1, fa} * {{SW{1'b0}}, 1'b1, fb};

  logic signed [XW-1:0] ep, ecx, dif, er_n;
  assign ep  = sx(ea) + sx(eb) - BIASX;
  assign ecx = sx(ec);

  logic          pbig;
  logic [WN-1:0] pwin, cwin, big_n, sraw;
  assign pwin = {prod, {(WN-PW){1'b0}}};
  assign cwin = {1'b0, 1'b1, fc, {(WN-SW-1){1'b0}}};
  assign pbig = cz | (!pz && (ep >= ecx));
  assign dif  = pbig ? (ep - ecx) : (ecx - ep);
  assign er_n = pbig ? ep : ecx;
  assign big_n = pbig ? (pz ? '0 : pwin) : cwin;
  assign sraw  = pbig ? (cz ? '0 : cwin) : (pz ? '0 : pwin);

  logic [XW-1:0]   sh;
  logic [2*WN-1:0] sfull;
  logic [WN-1:0]   sml_n;
  assign sh    = (dif < 0) ? '0 : ((dif > WNX) ? XW'(WN) : dif);
  assign sfull = {sraw, {WN{1'b0}}} >> sh;
  assign sml_n = sfull[2*WN-1:WN] | {{(WN-1){1'b0}}, |sfull[WN-1:0]};

  logic          spc_n;
  logic [FW-1:0] spv_n;
  always_comb begin
    spc_n = 1'b1;
    spv_n = QNAN;
    if (an | bn | cn | (ai & bz) | (bi & az) | ((ai | bi) & ci & (sp != sc)))
      spv_n = QNAN;
    else if (ai | bi)
      spv_n = PINF | {sp, {(FW-1){1'b0}}};
    else if (ci)
      spv_n = PINF | {sc, {(FW-1){1'b0}}};
    else if (pz & cz)
      spv_n = {sp & sc, {(FW-1){1'b0}}};
    else
      spc_n = 1'b0;
  end

  logic                 v2, sbig2, ssml2, sub2, spc2;
  logic [WN-1:0]        big2, sml2;
  logic signed [XW-1:0] er2;
  logic [FW-1:0]        spv2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v2 <= 1'b0; sbig2 <= 1'b0; ssml2 <= 1'b0; sub2 <= 1'b0; spc2 <= 1'b0;
      big2 <= '0; sml2 <= '0; er2 <= '0; spv2 <= '0;
    end else begin
      v2    <= v1;
      sbig2 <= pbig ? sp : sc;
      ssml2 <= pbig ? sc : sp;
      sub2  <= sp ^ sc;
      spc2  <= spc_n;
      big2  <= big_n;
      sml2  <= sml_n;
      er2   <= er_n;
      spv2  <= spv_n;
    end

  // stage 3: add / subtract and leading-zero count
  logic          ge;
  logic [WN:0]   sum;
  logic          sgn_n;
  logic [LZW-1:0] lz_n;
  assign ge    = (big2 >= sml2);
  assign sum   = !sub2 ? ({1'b0, big2} + {1'b0, sml2})
               : (ge ? ({1'b0, big2} - {1'b0, sml2}) : ({1'b0, sml2} - {1'b0, big2}));
  assign sgn_n = (sub2 && !ge) ? ssml2 : sbig2;

  always_comb begin
    lz_n = LZW'(WN + 1);
    for (int i = 0; i <= WN; i++)
      if (sum[i]) lz_n = LZW'(WN - i);
  end

  logic                 v3, s3, spc3;
  logic [WN:0]          m3;
  logic [LZW-1:0]       lz3;
  logic signed [XW-1:0] er3;
  logic [FW-1:0]        spv3;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      v3 <= 1'b0; s3 <= 1'b0; spc3 <= 1'b0; m3 <= '0; lz3 <= '0; er3 <= '0; spv3 <= '0;
    end else begin
      v3 <= v2; s3 <= sgn_n; spc3 <= spc2; m3 <= sum; lz3 <= lz_n; er3 <= er2; spv3 <= spv2;
    end

  // stage 4: normalize, round, overflow check
  logic [WN:0]          nrm;
  logic [SW-1:0]        mant;
  logic                 grd, stk, up;
  logic [SW:0]          rnd;
  logic signed [XW-1:0] ex4, ef;
  logic [FW-1:0]        res;
  assign nrm  = m3 << lz3;
  assign mant = nrm[WN -: SW];
  assign grd  = nrm[WN-SW];
  assign stk  = |nrm[WN-SW-1:0];
  assign up   = grd & (stk | mant[0]);
  assign rnd  = {1'b0, mant} + {{SW{1'b0}}, up};
  assign ex4  = er3 + XW'(2) - $signed({{(XW-LZW){1'b0}}, lz3});
  assign ef   = ex4 + $signed({{(XW-1){1'b0}}, rnd[SW]});

  always_comb begin
    if (spc3)               res = spv3;
    else if (m3 == '0)      res = '0;
    else if (ef >= EMAXX)   res = PINF | {s3, {(FW-1){1'b0}}};
    else if (ef <= 0)       res = {s3, {(FW-1){1'b0}}};
    else                    res = {s3, ef[EW-1:0], rnd[MW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0; y_out <= '0;
    end else begin
      out_valid <= v3; y_out <= res;
    end
endmodule

// File: rtl/hfma_chk.sv
module hfma_chk #(
  parameter int EW = 5,
  parameter int MW = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [EW+MW:0] a_in,
  input logic [EW+MW:0] b_in,
  input logic [EW+MW:0] c_in,
  input logic           out_valid,
  input logic [EW+MW:0] y_out
);
  localparam logic [EW+MW:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

  function automatic logic is_nan(input logic [EW+MW:0] x);
    return (x[EW+MW-1:MW] == {EW{1'b1}}) && (x[MW-1:0] != '0);
  endfunction

  logic [2:0] cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (cnt != 3'd4) cnt <= cnt + 3'd1;

  logic nan_in;
  assign nan_in = in_valid && (is_nan(a_in) || is_nan(b_in) || is_nan(c_in));

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 3'd4) |-> (out_valid == $past(in_valid, 4)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (y_out[EW+MW-1:MW] == {EW{1'b1}})) |-> ((y_out[MW-1:0] == '0) || (y_out == QNAN)));

  assert_no_subnormal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (y_out[EW+MW-1:MW] == '0)) |-> (y_out[MW-1:0] == '0));

  assert_nan_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt == 3'd4) && out_valid && $past(nan_in, 4)) |-> (y_out == QNAN));

  assert_reset_quiet_R7: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind hfma hfma_chk #(.EW(EW), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
  .c_in(c_in), .out_valid(out_valid), .y_out(y_out)
);

// File: tb/tb_hfma.sv
module tb_hfma;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] a_in = '0, b_in = '0, c_in = '0;
  logic out_valid;
  logic [15:0] y_out;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  hfma dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
            .c_in(c_in), .out_valid(out_valid), .y_out(y_out));

  bit          qv[$];
  logic [15:0] qy[$];
  string       qt[$];

  function automatic logic [15:0] ref_fma(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    logic sa, sb, sc, sp, az, bz, cz, ai, bi, ci, an, bn, cn, sg, up;
    int ea, eb, ec, k, sh, e;
    logic signed [131:0] pv, cv, sv;
    logic [131:0] m, mant, rem, half;
    sa = a[15]; sb = b[15]; sc = c[15]; sp = sa ^ sb;
    ea = int'(a[14:10]); eb = int'(b[14:10]); ec = int'(c[14:10]);
    az = (ea == 0); bz = (eb == 0); cz = (ec == 0);
    ai = (ea == 31) && (a[9:0] == 0); bi = (eb == 31) && (b[9:0] == 0); ci = (ec == 31) && (c[9:0] == 0);
    an = (ea == 31) && (a[9:0] != 0); bn = (eb == 31) && (b[9:0] != 0); cn = (ec == 31) && (c[9:0] != 0);
    if (an || bn || cn || (ai && bz) || (bi && az) || ((ai || bi) && ci && (sp != sc))) return 16'h7E00;
    if (ai || bi) return {sp, 15'h7C00};
    if (ci) return {sc, 15'h7C00};
    if ((az || bz) && cz) return {sp & sc, 15'h0};
    pv = 0; cv = 0;
    if (!(az || bz)) begin
      m  = {121'b0, 1'b1, a[9:0]} * {121'b0, 1'b1, b[9:0]};
      pv = $signed(m << (ea + eb - 2));
      if (sp) pv = -pv;
    end
    if (!cz) begin
      cv = $signed({121'b0, 1'b1, c[9:0]} << (ec + 23));
      if (sc) cv = -cv;
    end
    sv = pv + cv;
    if (sv == 0) return 16'h0000;
    sg = (sv < 0);
    m  = sg ? 132'(-sv) : 132'(sv);
    k = 0;
    for (int i = 0; i < 132; i++) if (m[i]) k = i;
    up = 1'b0;
    if (k >= 10) begin
      sh   = k - 10;
      mant = m >> sh;
      rem  = m & ((132'd1 << sh) - 1);
      half = (sh > 0) ? (132'd1 << (sh - 1)) : 132'd0;
      up   = (sh > 0) && ((rem > half) || ((rem == half) && mant[0]));
    end else begin
      mant = m << (10 - k);
    end
    e = k - 33;
    mant = mant + up;
    if (mant == 2048) begin mant = 1024; e = e + 1; end
    if (e >= 31) return {sg, 15'h7C00};
    if (e <= 0) return {sg, 15'h0};
    return {sg, 5'(e), mant[9:0]};
  endfunction

  task automatic check_out();
    bit ev; logic [15:0] ey; string t;
    if (qv.size() < 4) return;
    ev = qv.pop_front(); ey = qy.pop_front(); t = qt.pop_front();
    total++;
    if (out_valid !== ev) begin
      bad++;
      $display("FAIL R1 (%s): out_valid=%0b expected %0b", t, out_valid, ev);
    end
    if (ev) begin
      total++;
      if (y_out !== ey) begin
        bad++;
        $display("FAIL %s: y_out=%h expected %h", t, y_out, ey);
      end
    end
  endtask

  task automatic step(input bit v, input logic [15:0] a, input logic [15:0] b, input logic [15:0] c, input string tag);
    @(negedge clk);
    check_out();
    in_valid = v; a_in = a; b_in = b; c_in = c;
    qv.push_back(v);
    qy.push_back(v ? ref_fma(a, b, c) : 16'h0);
    qt.push_back(tag);
  endtask

  function automatic logic [15:0] rnorm(input int e);
    return {1'($urandom), 5'(e), 10'($urandom)};
  endfunction

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(negedge clk);
    total++;
    if (out_valid !== 1'b0 || y_out !== 16'h0) begin
      bad++;
      $display("FAIL R7: out_valid=%0b y_out=%h expected 0 0000", out_valid, y_out);
    end
    @(negedge clk);
    rst_n = 1'b1;

    step(1, 16'h3C00, 16'h3C00, 16'h3C00, "R2 1*1+1");
    step(1, 16'h4000, 16'h4200, 16'hBC00, "R2 2*3-1");
    step(0, 16'h1234, 16'h5678, 16'h9ABC, "R1 bubble");
    step(1, 16'h3C00, 16'h3C00, 16'hBC00, "R4 cancel");
    step(1, 16'hBC00, 16'h3C00, 16'h3C00, "R4 cancel neg");
    step(1, 16'h0000, 16'h0000, 16'h8000, "R4 zero mixed sign");
    step(1, 16'h8000, 16'h3C00, 16'h8000, "R4 zero both neg");
    step(0, 16'h0, 16'h0, 16'h0, "R1 bubble");
    step(0, 16'h0, 16'h0, 16'h0, "R1 bubble");
    step(1, 16'h7BFF, 16'h4000, 16'h0000, "R3 overflow pos");
    step(1, 16'h7BFF, 16'hC000, 16'h0000, "R3 overflow neg");
    step(1, 16'h7BFF, 16'h3C00, 16'h4C00, "R3 R8 carry to inf");
    step(1, 16'h3BFF, 16'h3C00, 16'h3C00, "R8 carry");
    step(1, 16'h7C00, 16'h0000, 16'h3C00, "R6 inf*0");
    step(1, 16'h7C00, 16'h3C00, 16'hFC00, "R6 inf-inf");
    step(1, 16'h7C00, 16'h4000, 16'h4200, "R6 inf prod");
    step(1, 16'h3C00, 16'h3C00, 16'hFC00, "R6 inf addend");
    step(1, 16'h3C00, 16'h3C00, 16'h7C01, "R6 nan addend");
    step(1, 16'hFE00, 16'h3C00, 16'h3C00, "R6 nan operand");
    step(1, 16'h0001, 16'h3C00, 16'h3C00, "R5 subnormal in");
    step(1, 16'h0400, 16'h3800, 16'h0000, "R5 flush pos");
    step(1, 16'h8400, 16'h3800, 16'h0000, "R5 flush neg");
    step(1, 16'h3C00, 16'h3C00, 16'h1000, "R9 tie even add");
    step(1, 16'h3C00, 16'h3C00, 16'h1001, "R9 above tie add");
    step(1, 16'h3C00, 16'h3C00, 16'h8C00, "R9 tie even sub");
    step(1, 16'h3C00, 16'h3C00, 16'h8C01, "R9 above tie sub");
    step(1, 16'h7000, 16'h3C00, 16'h0400, "R9 far add");
    step(1, 16'h7000, 16'h3C00, 16'h8400, "R9 far sub");
    step(1, 16'h3555, 16'h4AAB, 16'h0000, "R2 product only");
    step(1, 16'h0000, 16'h4AAB, 16'hC123, "R5 zero product");

    for (int n = 0; n < 3000; n++) begin
      int ea, eb, ec;
      ea = 1 + int'($urandom % 30);
      eb = 1 + int'($urandom % 30);
      if (n % 2 == 0) ec = 1 + int'($urandom % 30);
      else begin
        ec = ea + eb - 15 + int'($urandom % 7) - 3;
        if (ec < 1) ec = 1;
        if (ec > 30) ec = 30;
      end
      step(($urandom % 6) != 0, rnorm(ea), rnorm(eb), rnorm(ec), "R2 random");
    end
    repeat (5) step(0, 16'h0, 16'h0, 16'h0, "R1 drain");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule